// File: doc/BRIEF.md
# Jittered Fractional Baud Generator

This block produces the bit timing for one direction of a serial line from a fast source clock. An 8-bit divisor value sets the length of a sample interval, which is one sixteenth of a nominal bit. While a frame runs, the block pulses a sample tick at the end of every sample interval. It also pulses a bit-end strobe on the last sample tick of each bit and shows the index of the bit in progress.

An integer divisor alone leaves a rate error that grows with every bit of a frame. To offset it, each bit position can be given a 2-bit adjustment code that makes that bit one sample interval longer or shorter. The codes are packed into a pattern word indexed by bit position. A transmitter and a receiver each use their own instance with their own pattern word, and both share the same divisor value. A frame has a start bit, the data bits, an optional parity bit and the stop bits. It is launched by a one-cycle start strobe together with its length in bits. When the last bit of the frame has ended, the block goes idle.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is held and after reset is released, `busy`, `sample_tick` and `bit_end` are 0 and `bit_idx` is 0 until a frame is started.
- R2: During a frame, `sample_tick` pulses for one cycle every `div_val`+1 source clocks. The first pulse comes in the (`div_val`+1)-th cycle after the clock edge that samples `frame_start`.
- R3: Bit n of a frame reads the adjustment code at `jit_pattern[2n+1:2n]`. Code 00 gives 16 sample intervals, 01 gives 17, 10 gives 15 and 11 gives 16. A bit therefore lasts that many times (`div_val`+1) source clocks.
- R4: `bit_end` is high in exactly the cycle of the last sample tick of each bit. `bit_idx` shows the current bit, counting from 0, and advances by one after each `bit_end`.
- R5: After the `bit_end` of bit `frame_len`-1, the block is idle. `busy` is 0 and neither strobe pulses until the next start.
- R6: A `frame_start` that arrives during a frame restarts it at bit 0 with fresh interval and tick counts.
- R7: A `frame_start` with `frame_len` equal to 0 is ignored. A length above 12 is treated as 12.
- R8: A `div_val` of 0 works: a tick pulses on every clock, and the codes give bits of 17, 15 and 16 clocks.
- R9: The frame length is captured at the start. A change of `frame_len` during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | 8 | Divisor minus one; sample interval is div_val+1 clocks |
| jit_pattern | input | 24 | Per-bit 2-bit adjustment codes, bit n at [2n+1:2n] |
| frame_len | input | 4 | Frame length in bits, captured at start |
| frame_start | input | 1 | One-cycle strobe that starts (or restarts) a frame |
| sample_tick | output | 1 | One-cycle pulse at the end of each sample interval |
| bit_end | output | 1 | One-cycle pulse on the last sample tick of a bit |
| bit_idx | output | 4 | Index of the bit in progress |
| busy | output | 1 | High while a frame is running |

## Verification
Two events can fall in the same cycle: the closing tick of a bit, where `bit_end` coincides with a `sample_tick`, and a possible end of frame. With a divisor of 0 every clock is a tick, so the adjustment codes move the bit boundary by exactly one clock. The bench counts clocks and ticks between successive boundaries and compares them with (16±1)·(div+1). A restart strobe issued in the middle of a bit checks that a new start takes priority over the running count: the next measured bit must begin at index 0 with a full-length period.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

  localparam int SUBS_PER_BIT = 16;
  localparam int SUB_W        = 5;

  typedef enum logic [1:0] {
    JC_NOMINAL = 2'b00,
    JC_WIDEN   = 2'b01,
    JC_NARROW  = 2'b10,
    JC_SPARE   = 2'b11
  } jit_code_e;

  // Index of the final sample interval of a bit for a given code.
  function automatic logic [SUB_W-1:0] final_sub(input jit_code_e code);
    case (code)
      JC_WIDEN:  final_sub = SUB_W'(SUBS_PER_BIT);
      JC_NARROW: final_sub = SUB_W'(SUBS_PER_BIT - 2);
      default:   final_sub = SUB_W'(SUBS_PER_BIT - 1);
    endcase
  endfunction

endpackage

// File: rtl/fbg_prescaler.sv
module fbg_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);

  logic [DIV_W-1:0] pre_q, pre_d;
  logic             pre_en;

  assign tick   = run && (pre_q == div_val);
  assign pre_en = restart || run;

  always_comb begin
    pre_d = pre_q;
    if (restart)   pre_d = '0;
    else if (tick) pre_d = '0;
    else if (run)  pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end

  // R2: the interval counter never runs past the divisor while active
  a_r2_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pre_q <= div_val));

  // R2: with a divisor above zero, ticks are never back to back
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_val != '0 && !restart) |=> !tick);

endmodule

// File: rtl/fbg_jitter_sel.sv
module fbg_jitter_sel
  import fbg_pkg::*;
#(
  parameter int MAX_BITS = 12,
  parameter int IDX_W    = 4
) (
  input  logic [2*MAX_BITS-1:0] jit_pattern,
  input  logic [IDX_W-1:0]      bit_idx,
  output logic [SUB_W-1:0]      last_sub
);

  jit_code_e code_arr [MAX_BITS];
  jit_code_e cur_code;

  for (genvar g = 0; g < MAX_BITS; g++) begin : g_field
    assign code_arr[g] = jit_code_e'(jit_pattern[2*g +: 2]);
  end

  always_comb begin
    cur_code = JC_NOMINAL;
    for (int i = 0; i < MAX_BITS; i++) begin
      if (bit_idx == IDX_W'(i)) cur_code = code_arr[i];
    end
  end

  assign last_sub = final_sub(cur_code);

endmodule

// File: rtl/fbg_bit_seq.sv
module fbg_bit_seq
  import fbg_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [IDX_W-1:0] len_in,
  input  logic             tick,
  input  logic [SUB_W-1:0] last_sub,
  output logic             active,
  output logic             bit_end,
  output logic [IDX_W-1:0] bit_idx
);

  logic             act_q, act_d;
  logic [SUB_W-1:0] sub_q, sub_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] len_q, len_d;
  logic             last_bit;
  logic             seq_en;

  assign bit_end  = act_q && tick && (sub_q == last_sub);
  assign last_bit = (idx_q == len_q - 1'b1);
  assign seq_en   = restart || (act_q && tick);

  always_comb begin
    act_d = act_q;
    sub_d = sub_q;
    idx_d = idx_q;
    len_d = len_q;
    if (restart) begin
      act_d = 1'b1;
      sub_d = '0;
      idx_d = '0;
      len_d = len_in;
    end else if (act_q && tick) begin
      if (bit_end) begin
        sub_d = '0;
        if (last_bit) begin
          act_d = 1'b0;
          idx_d = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end else begin
        sub_d = sub_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      sub_q <= '0;
      idx_q <= '0;
      len_q <= '0;
    end else if (seq_en) begin
      act_q <= act_d;
      sub_q <= sub_d;
      idx_q <= idx_d;
      len_q <= len_d;
    end
  end

  assign active  = act_q;
  assign bit_idx = idx_q;

  // R4: the bit index stays inside the captured frame length
  a_r4_idx_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (idx_q < len_q));

  // R3: the sample interval count never exceeds the widened bit
  a_r3_sub_bound: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (sub_q <= SUB_W'(SUBS_PER_BIT)));

  // R5: the end of the final bit leads to idle
  a_r5_end_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && last_bit && !restart) |=> !act_q);

  // R4: a non-final bit end moves to the next index
  a_r4_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && !last_bit && !restart) |=> (idx_q == $past(idx_q) + 1'b1));

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int MAX_BITS = 12,
  parameter int IDX_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DIV_W-1:0]      div_val,
  input  logic [2*MAX_BITS-1:0] jit_pattern,
  input  logic [IDX_W-1:0]      frame_len,
  input  logic                  frame_start,
  output logic                  sample_tick,
  output logic                  bit_end,
  output logic [IDX_W-1:0]      bit_idx,
  output logic                  busy
);

  localparam logic [IDX_W-1:0] LEN_CAP = IDX_W'(MAX_BITS);

  logic             restart;
  logic [IDX_W-1:0] len_eff;
  logic             active;
  logic             tick;
  logic [SUB_W-1:0] last_sub;
  logic [IDX_W-1:0] idx;

  assign restart = frame_start && (frame_len != '0);
  assign len_eff = (frame_len > LEN_CAP) ? LEN_CAP : frame_len;

  fbg_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (active),
    .restart (restart),
    .div_val (div_val),
    .tick    (tick)
  );

  fbg_jitter_sel #(.MAX_BITS(MAX_BITS), .IDX_W(IDX_W)) u_jit (
    .jit_pattern (jit_pattern),
    .bit_idx     (idx),
    .last_sub    (last_sub)
  );

  fbg_bit_seq #(.IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .len_in   (len_eff),
    .tick     (tick),
    .last_sub (last_sub),
    .active   (active),
    .bit_end  (bit_end),
    .bit_idx  (idx)
  );

  assign sample_tick = tick;
  assign bit_idx     = idx;
  assign busy        = active;

  // R5: no strobe pulses while idle
  a_r5_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sample_tick && !bit_end));

  // R6: an accepted start always lands on bit 0 of a running frame
  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (busy && bit_idx == '0));

  // R7: a zero-length start leaves an idle block idle
  a_r7_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && frame_len == '0 && !busy) |=> !busy);

  // R4: a bit boundary is always a sample tick
  a_r4_end_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end |-> sample_tick);

endmodule

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  div_val;
  logic [23:0] jit_pattern;
  logic [3:0]  frame_len;
  logic        frame_start;
  logic        sample_tick, bit_end, busy;
  logic [3:0]  bit_idx;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  frac_baud_gen u0 (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .jit_pattern(jit_pattern),
    .frame_len(frame_len), .frame_start(frame_start),
    .sample_tick(sample_tick), .bit_end(bit_end), .bit_idx(bit_idx), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bit_subs(input logic [23:0] p, input int b);
    logic [1:0] c = p[2*b +: 2];
    if (c == 2'b01) return 17;
    if (c == 2'b10) return 15;
    return 16;
  endfunction

  task automatic pulse_start(input logic [3:0] len);
    @(negedge clk);
    frame_len   = len;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  // Measures one frame; the first sample is taken in the first cycle after the start edge.
  task automatic run_frame(input logic [7:0] d, input logic [23:0] p,
                           input logic [3:0] len, input int nbits,
                           input logic [3:0] len_mid, input string req);
    div_val     = d;
    jit_pattern = p;
    @(negedge clk);
    frame_len   = len;
    frame_start = 1'b1;
    @(posedge clk);
    #1 frame_start = 1'b0;
    frame_len = len_mid;
    for (int b = 0; b < nbits; b++) begin
      int cyc = 0;
      int tk = 0;
      int first_tick = 0;
      bit seen = 0;
      while (!seen && cyc < 20000) begin
        @(negedge clk);
        cyc++;
        if (sample_tick) begin
          tk++;
          if (tk == 1) first_tick = cyc;
        end
        if (bit_end) begin
          seen = 1;
          check(bit_idx == 4'(b), {req, " R4 bit_idx"}, bit_idx, b);
        end
      end
      check(cyc == bit_subs(p, b) * (d + 1), {req, " R3 bit clocks"}, cyc, bit_subs(p, b) * (d + 1));
      check(tk == bit_subs(p, b), {req, " R3 bit ticks"}, tk, bit_subs(p, b));
      if (b == 0) check(first_tick == d + 1, {req, " R2 first tick"}, first_tick, d + 1);
    end
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (busy || sample_tick || bit_end) begin
        check(0, {req, " R5 idle after frame"}, {busy, sample_tick, bit_end}, 0);
        break;
      end
    end
    check(!busy && bit_idx == 0, {req, " R5 idle state"}, busy, 0);
  endtask

  task automatic t_reset;
    check(!busy && !sample_tick && !bit_end && bit_idx == 0, "R1 in reset", busy, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !sample_tick && !bit_end && bit_idx == 0, "R1 after reset", busy, 0);
  endtask

  task automatic t_nominal;
    run_frame(8'd2, 24'h0, 4'd10, 10, 4'd10, "nominal");
  endtask

  task automatic t_mixed_div3;
    run_frame(8'd3, 24'b00_00_00_00_00_00_00_00_11_10_01_00, 4'd4, 4, 4'd4, "mixed");
  endtask

  task automatic t_div0_full;
    // R8: divisor of zero, every code used, length 15 clamps to 12 (R7)
    run_frame(8'd0, 24'b01_10_11_00_10_01_10_01_11_00_10_01, 4'd15, 12, 4'd15, "R8 R7 div0");
  endtask

  task automatic t_zero_len;
    div_val = 8'd1;
    pulse_start(4'd0);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (busy || sample_tick) begin
        check(0, "R7 zero length ignored", busy, 0);
        break;
      end
    end
    check(!busy, "R7 zero length idle", busy, 0);
  endtask

  task automatic t_restart;
    div_val = 8'd1;
    jit_pattern = 24'h0;
    pulse_start(4'd3);
    repeat (45) @(negedge clk);   // inside bit 1, mid-interval
    check(busy && bit_idx == 1, "R6 running before restart", bit_idx, 1);
    run_frame(8'd1, 24'b01_10, 4'd2, 2, 4'd2, "R6 restart");
  endtask

  task automatic t_len_latch;
    run_frame(8'd0, 24'b10_01_00, 4'd3, 3, 4'd1, "R9 latched length");
  endtask

  initial begin
    rst_n = 1'b0;
    div_val = '0;
    jit_pattern = '0;
    frame_len = '0;
    frame_start = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_nominal();
    t_mixed_div3();
    t_div0_full();
    t_zero_len();
    t_restart();
    t_len_latch();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule